// File: doc/BRIEF.md
# Streaming RGB Alpha Blender

This unit mixes two streams of 32-bit true-color pixels into one. Each input beat carries a pixel from the destination stream and a pixel from the source stream. The unit weights the destination pixel by an 8-bit alpha and the source pixel by 256 minus alpha, adds the two, and divides by 256. The result is the pixel that overwrites the destination. All arithmetic runs in parallel on three 16-bit lanes, one each for red, green and blue.

Software loads an alpha and a pixel count, then pulses start. The unit then accepts exactly that many input beats on a valid/ready stream. It emits the same number of blended beats, in the same order, on a valid/ready output stream. When the last beat leaves, it raises done. Backpressure on the output stalls the whole pipeline, and the input stream stalls with it.

Top module: `rgb_alpha_blend`

## Requirements
- R1: After reset, busy, done, out_valid and in_ready are all 0.
- R2: Pixels use bits 23:16 for red, 15:8 for green and 7:0 for blue. For each of these channels, the output channel equals (D*alpha + S*(256-alpha)) >> 8. D is that channel of in_dst_px, S is that channel of in_src_px, and alpha is the value captured at start.
- R3: With alpha 0 the source weight is exactly 256, so the low 24 output bits equal the low 24 bits of in_src_px.
- R4: Output bits 31:24 are always 0, and input bits 31:24 have no effect on the result.
- R5: When out_ready is held high, a beat accepted in cycle c is presented on the output in cycle c+3.
- R6: While out_valid is 1 and out_ready is 0, out_valid and out_px hold their values in the next cycle.
- R7: A run of N accepts exactly N input beats and emits exactly N output beats, in input order. After the Nth accept, in_ready stays 0. Outside a run, out_valid and in_ready are 0.
- R8: In the cycle after the last output handshake, busy is 0 and done is 1. Done stays 1 until start is pulsed again, and a start with a nonzero count clears it.
- R9: A start with count 0 sets done in the next cycle. It leaves busy at 0 and produces no output beats.
- R10: cfg_alpha and cfg_count are sampled only on an accepted start. Changes to them, and start pulses while busy is 1, do not affect the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| cfg_alpha | input | 8 | Destination weight, sampled at start |
| cfg_count | input | COUNT_W | Number of pixels in the run, sampled at start |
| busy | output | 1 | A run is in progress |
| done | output | 1 | The last run has finished |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted when valid is also high |
| in_dst_px | input | 32 | Destination pixel |
| in_src_px | input | 32 | Source pixel |
| out_valid | output | 1 | Blended beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_px | output | 32 | Blended pixel |

## Verification
Accepting a new input beat and emitting a finished one often happen in the same clock edge. Both depend on the shared advance condition, so a slip between them would drop or duplicate a pixel. The bench provokes this by streaming back-to-back inputs while toggling out_ready on a fixed pattern, and separately by opening gaps in in_valid. It judges each output beat in arrival order against a reference blend, and counts accepted and emitted beats against the programmed count. A start pulse and a change of configuration are also placed in the middle of a run, to show that they are ignored.

// File: rtl/blend_pkg.sv
package blend_pkg;
    localparam int CH_W        = 8;
    localparam int LANE_W      = 16;
    localparam int LANES       = 4;
    localparam int COLOR_LANES = 3;
    localparam int PIX_W       = LANES * CH_W;
    localparam int WGT_W       = CH_W + 1;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] lanes_t;
    typedef logic [PIX_W-1:0]  pixel_t;

    typedef struct packed {
        lanes_t dst;
        lanes_t src;
    } lane_pair_t;

    // Widen each colour byte into its own lane; the top lane is forced to zero.
    function automatic lanes_t spread_pixel(pixel_t px);
        lanes_t l;
        for (int i = 0; i < LANES; i++) begin
            if (i < COLOR_LANES) l[i] = lane_t'(px[i*CH_W +: CH_W]);
            else                 l[i] = '0;
        end
        return l;
    endfunction

    function automatic lane_t add_clamp(lane_t x, lane_t y);
        logic [LANE_W:0] s;
        s = {1'b0, x} + {1'b0, y};
        return s[LANE_W] ? {LANE_W{1'b1}} : s[LANE_W-1:0];
    endfunction

    function automatic logic [CH_W-1:0] narrow_clamp(lane_t v);
        return (v > lane_t'({CH_W{1'b1}})) ? {CH_W{1'b1}} : v[CH_W-1:0];
    endfunction

    function automatic pixel_t gather_pixel(lanes_t l);
        pixel_t px;
        px = '0;
        for (int i = 0; i < COLOR_LANES; i++) px[i*CH_W +: CH_W] = narrow_clamp(l[i]);
        return px;
    endfunction
endpackage

// File: rtl/blend_weights.sv
module blend_weights
    import blend_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [CH_W-1:0] alpha_in,
    output lane_t           w_dst,
    output lane_t           w_src
);
    localparam logic [WGT_W-1:0] FULL_SCALE = WGT_W'(1) << CH_W;

    logic [CH_W-1:0]  alpha_q;
    logic [WGT_W-1:0] comp_q;   // 9 bits so that alpha 0 yields exactly 256

    always_ff @(posedge clk) begin
        if (rst) begin
            alpha_q <= '0;
            comp_q  <= FULL_SCALE;
        end else if (load) begin
            alpha_q <= alpha_in;
            comp_q  <= FULL_SCALE - WGT_W'(alpha_in);
        end
    end

    assign w_dst = lane_t'(alpha_q);
    assign w_src = lane_t'(comp_q);
endmodule

// File: rtl/blend_datapath.sv
module blend_datapath
    import blend_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    input  logic   in_fire,
    input  pixel_t dst_px,
    input  pixel_t src_px,
    input  lane_t  w_dst,
    input  lane_t  w_src,
    output logic   out_valid,
    output pixel_t out_px
);
    logic       v1, v2, v3;
    lane_pair_t s1;
    lane_pair_t s2;
    pixel_t     s3_px;
    lanes_t     prod_dst, prod_src, mixed;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else if (adv) begin
            v1 <= in_fire;
            v2 <= v1;
            v3 <= v2;
        end
    end

    // Stage 1: unpack into lanes
    always_ff @(posedge clk) begin
        if (adv && in_fire) begin
            s1.dst <= spread_pixel(dst_px);
            s1.src <= spread_pixel(src_px);
        end
    end

    // Per-lane weighting and mixing
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g < COLOR_LANES) begin : g_color
            assign prod_dst[g] = lane_t'(s1.dst[g] * w_dst);
            assign prod_src[g] = lane_t'(s1.src[g] * w_src);
            assign mixed[g]    = add_clamp(s2.dst[g], s2.src[g]) >> CH_W;
        end else begin : g_pad
            assign prod_dst[g] = '0;
            assign prod_src[g] = '0;
            assign mixed[g]    = '0;
        end
    end

    // Stage 2: weighted products
    always_ff @(posedge clk) begin
        if (adv) begin
            s2.dst <= prod_dst;
            s2.src <= prod_src;
        end
    end

    // Stage 3: sum, scale and repack
    always_ff @(posedge clk) begin
        if (adv) s3_px <= gather_pixel(mixed);
    end

    assign out_valid = v3;
    assign out_px    = s3_px;
endmodule

// File: rtl/blend_run_ctrl.sv
module blend_run_ctrl #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             in_fire,
    input  logic             out_fire,
    output logic             load,
    output logic             busy,
    output logic             done,
    output logic             feed_open
);
    logic [CNT_W-1:0] in_left, out_left;

    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            in_left  <= '0;
            out_left <= '0;
        end else if (load) begin
            if (cnt_in == '0) begin
                done <= 1'b1;
            end else begin
                busy     <= 1'b1;
                done     <= 1'b0;
                in_left  <= cnt_in;
                out_left <= cnt_in;
            end
        end else if (busy) begin
            if (in_fire) in_left <= in_left - 1'b1;
            if (out_fire) begin
                out_left <= out_left - 1'b1;
                if (out_left == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign feed_open = busy && (in_left != '0);
endmodule

// File: rtl/rgb_alpha_blend.sv
module rgb_alpha_blend
    import blend_pkg::*;
#(
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CH_W-1:0]    cfg_alpha,
    input  logic [COUNT_W-1:0] cfg_count,
    output logic               busy,
    output logic               done,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [PIX_W-1:0]   in_dst_px,
    input  logic [PIX_W-1:0]   in_src_px,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PIX_W-1:0]   out_px
);
    logic  load, feed_open, adv, in_fire, out_fire;
    lane_t w_dst, w_src;

    assign adv      = !out_valid || out_ready;
    assign in_ready = feed_open && adv;
    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    blend_run_ctrl #(.CNT_W(COUNT_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cnt_in    (cfg_count),
        .in_fire   (in_fire),
        .out_fire  (out_fire),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .feed_open (feed_open)
    );

    blend_weights u_wgt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .alpha_in (cfg_alpha),
        .w_dst    (w_dst),
        .w_src    (w_src)
    );

    blend_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .in_fire   (in_fire),
        .dst_px    (in_dst_px),
        .src_px    (in_src_px),
        .w_dst     (w_dst),
        .w_src     (w_src),
        .out_valid (out_valid),
        .out_px    (out_px)
    );
endmodule

// File: rtl/blend_checker.sv
module blend_checker
    import blend_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [PIX_W-1:0] out_px
);
    AST_TOP_BYTE_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_px[PIX_W-1 -: CH_W] == '0)); // R4

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_px))); // R6

    AST_OUT_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy); // R7

    AST_IN_ONLY_IN_RUN: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> busy); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_END_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R8
endmodule

bind rgb_alpha_blend blend_checker u_chk (.*);

// File: tb/tb_rgb_alpha_blend.sv
module tb_rgb_alpha_blend;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  cfg_alpha = '0;
    logic [15:0] cfg_count = '0;
    logic        busy, done;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_dst_px = '0;
    logic [31:0] in_src_px = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_px;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    rgb_alpha_blend dut (
        .clk(clk), .rst(rst), .start(start), .cfg_alpha(cfg_alpha), .cfg_count(cfg_count),
        .busy(busy), .done(done), .in_valid(in_valid), .in_ready(in_ready),
        .in_dst_px(in_dst_px), .in_src_px(in_src_px), .out_valid(out_valid),
        .out_ready(out_ready), .out_px(out_px)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] ref_blend(logic [31:0] d, logic [31:0] s, logic [7:0] al);
        logic [31:0] r;
        int v;
        r = '0;
        for (int ch = 0; ch < 3; ch++) begin
            v = (int'(d[8*ch +: 8]) * int'(al) + int'(s[8*ch +: 8]) * (256 - int'(al))) >> 8;
            r[8*ch +: 8] = 8'(v);
        end
        return r;
    endfunction

    function automatic logic [31:0] gen_px(int i, int seed);
        logic [31:0] h;
        h = 32'(i + 1) * 32'h9E3779B1 ^ 32'(seed) * 32'h85EBCA77;
        return h ^ (h >> 13);
    endfunction

    task automatic do_start(logic [7:0] al, int n);
        @(negedge clk);
        cfg_alpha = al;
        cfg_count = 16'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        if (n > 0) chk(busy && !done, "R8", {30'b0, busy, done}, 32'h2);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!busy && !done && !out_valid && !in_ready, "R1",
            {28'b0, busy, done, out_valid, in_ready}, 32'h0);
    endtask

    task automatic t_zero_count();
        do_start(8'd90, 0);
        chk(done && !busy && !out_valid, "R9", {29'b0, done, busy, out_valid}, 32'h4);
        in_valid = 1'b1;
        out_ready = 1'b1;
        repeat (3) begin
            @(negedge clk);
            #1;
            chk(!out_valid && !in_ready && !busy, "R9", {29'b0, out_valid, in_ready, busy}, 32'h0);
        end
        in_valid = 1'b0;
    endtask

    // mode 0: free flow, 1: output stalls, 2: input gaps; seed<0 -> extreme pixels
    task automatic run_case(logic [7:0] al, int n, int mode, int seed, bit disturb);
        logic [31:0] d[64];
        logic [31:0] s[64];
        logic [31:0] e[64];
        int acc_cyc[64];
        int in_i, out_i, cyc;
        bit stalled;
        logic [31:0] held;
        string req;
        req = disturb ? "R10" : "R2";
        for (int i = 0; i < n; i++) begin
            if (seed < 0) begin
                d[i] = (i % 2 == 0) ? 32'hFFFFFFFF : 32'h00000000;
                s[i] = (i % 2 == 0) ? 32'h00000000 : 32'hFFFFFFFF;
            end else begin
                d[i] = gen_px(i, seed);
                s[i] = gen_px(i + 100, seed);
            end
            e[i] = ref_blend(d[i], s[i], al);
        end
        do_start(al, n);
        in_i = 0; out_i = 0; cyc = 0; stalled = 0; held = '0;
        while (out_i < n && cyc < 2000) begin
            @(negedge clk);
            out_ready = (mode == 1) ? (cyc % 3 != 0) : 1'b1;
            in_valid  = (in_i < n) && ((mode == 2) ? (cyc % 4 != 1) : 1'b1);
            in_dst_px = (in_i < n) ? d[in_i] : 32'h0;
            in_src_px = (in_i < n) ? s[in_i] : 32'h0;
            if (disturb && (cyc == 2 || cyc == 3)) begin
                cfg_alpha = ~al;
                cfg_count = 16'd3;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            #1;
            if (stalled) chk(out_valid && out_px == held, "R6", out_px, held);
            stalled = out_valid && !out_ready;
            held = out_px;
            if (in_valid && in_ready) begin
                acc_cyc[in_i] = cyc;
                in_i++;
            end
            if (out_valid && out_ready) begin
                chk(out_px == e[out_i], req, out_px, e[out_i]);
                chk(out_px[31:24] == 8'h00, "R4", {24'b0, out_px[31:24]}, 32'h0);
                if (al == 8'd0)
                    chk(out_px == {8'h00, s[out_i][23:0]}, "R3", out_px, {8'h00, s[out_i][23:0]});
                if (mode == 0)
                    chk(cyc == acc_cyc[out_i] + 3, "R5", 32'(cyc), 32'(acc_cyc[out_i] + 3));
                out_i++;
            end
            cyc++;
        end
        start = 1'b0;
        chk(out_i == n, "R7", 32'(out_i), 32'(n));
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1;
        #1;
        chk(done && !busy, "R8", {30'b0, done, busy}, 32'h2);
        chk(in_i == n, "R7", 32'(in_i), 32'(n));
        repeat (4) begin
            @(negedge clk);
            #1;
            chk(!in_ready && !out_valid, "R7", {30'b0, in_ready, out_valid}, 32'h0);
        end
        chk(done, "R8", {31'b0, done}, 32'h1);
        in_valid = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero_count();
        run_case(8'd128, 8, 0, 1, 1'b0);
        run_case(8'd0, 6, 0, 2, 1'b0);
        run_case(8'd255, 9, 1, -1, 1'b0);
        run_case(8'd77, 20, 2, 3, 1'b0);
        run_case(8'd200, 10, 1, 4, 1'b1);
        run_case(8'd33, 12, 0, 5, 1'b1);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule